// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Port Host Controller

This block is the host side of a four-wire serial link to a sigma-delta converter whose port runs with an externally supplied bit clock. It generates the bit clock from the system clock, drives two active-low frame strobes (a receive strobe `adc_rfs_n` and a transmit strobe `adc_tfs_n`) and a register-select line `adc_a0`, and uses one shared data line. The line is brought out as a driven bit, an output enable for an external tristate buffer, and an input.

A user issues one of four 2-bit commands through a request/acknowledge port. The commands are a conversion-result read, a control-register read, a control-register write and a calibration-register write. The controller picks the strobe and register select, waits for the active-low data-ready input when the command needs it, and shifts a 24-bit word with the most significant bit first on the wire. It then returns the received word together with a one-cycle acknowledge.

Two static wiring options are offered. In the first, the transmit strobe is the inverse of the receive strobe. In the second, register select copies the transmit strobe. A third option reverses bit order inside each byte on the user side, for hosts that expect bytes least significant bit first.

Top module: `sdadc_host_ctrl`

## Requirements
- R1: After reset, with all options clear, `adc_rfs_n`, `adc_tfs_n` and `adc_sclk` are high, and `req_ack` and `adc_sd_oe` are low.
- R2: A conversion read (`req_cmd`=0) does not lower `adc_rfs_n` while `adc_drdy_n` is high. The frame starts only after `adc_drdy_n` has been sampled low.
- R3: A conversion read lowers `adc_rfs_n` with `adc_a0` high and shifts in 24 bits MSB first, one bit on each rising `adc_sclk`. The word is returned on `rsp_rdata` when `req_ack` is high.
- R4: A control read (`req_cmd`=1) holds `adc_a0` low while `adc_rfs_n` is low and ignores `adc_drdy_n`.
- R5: A control write (`req_cmd`=2) lowers `adc_tfs_n` with `adc_a0` low and sends `req_wdata` MSB first. Each bit is changed on a falling `adc_sclk` edge and held stable while the clock is high.
- R6: A calibration write (`req_cmd`=3) lowers `adc_tfs_n` with `adc_a0` high and sends 24 bits MSB first.
- R7: `adc_sd_oe` is high exactly when `adc_tfs_n` is low, so the line is released during every read frame.
- R8: Within a frame, each low phase and each high phase of `adc_sclk` lasts `HALF_DIV` system clock cycles.
- R9: With `cfg_tfs_inv` set, `adc_tfs_n` is always the inverse of `adc_rfs_n`. A write is then carried out with `adc_rfs_n` high, and `adc_rfs_n` is never derived from `adc_tfs_n`.
- R10: With `cfg_a0_tfs` set, `adc_a0` copies `adc_tfs_n`, so a calibration write reaches the control register with `adc_a0` low. A control read in this mode completes without any frame and returns zero.
- R11: With `cfg_byte_rev` set, bit i of every byte of `req_wdata` goes on the wire as bit 7-i of that byte. Received words are mapped back the same way, so that 0x010203 is sent as 0x8040C0.
- R12: `req_ack` is a single-cycle pulse, one per command. Without `cfg_tfs_inv`, the two strobes are never low together.
- R13: `adc_sclk` falls only while a strobe is low. When `req_ack` is high, the strobes are already back high (without `cfg_tfs_inv`) and `adc_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_rev | input | 1 | Reverse bit order within each byte on the user side |
| cfg_tfs_inv | input | 1 | Transmit strobe is the inverse of the receive strobe |
| cfg_a0_tfs | input | 1 | Register select copies the transmit strobe |
| req_valid | input | 1 | Command request, held until acknowledged |
| req_cmd | input | 2 | 0 conversion read, 1 control read, 2 control write, 3 calibration write |
| req_wdata | input | 24 | Word to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 24 | Word read, valid with `req_ack` |
| adc_drdy_n | input | 1 | Active-low data-ready from the converter |
| adc_sclk | output | 1 | Serial bit clock, idles high |
| adc_rfs_n | output | 1 | Active-low receive frame strobe |
| adc_tfs_n | output | 1 | Active-low transmit frame strobe |
| adc_a0 | output | 1 | Register select |
| adc_sd_out | output | 1 | Data bit driven toward the converter |
| adc_sd_oe | output | 1 | Enable for the external data line buffer |
| adc_sd_in | input | 1 | Data bit from the converter |

## Verification
The hardest case to reach is a conversion read that sits on the data-ready gate. A request has to stay pending for many cycles while `adc_drdy_n` is high, and no strobe edge may appear in that time. The bench issues the read with data-ready held high, counts receive-strobe falls over a long wait, and only then lowers data-ready. The wiring options are also hard to reach, because they change which strobe carries a write. The bench switches them between transactions and observes the strobes and the register select at every rising bit-clock edge through a simple converter model.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  typedef enum logic [1:0] {
    CMD_DATA_RD = 2'd0,
    CMD_CTRL_RD = 2'd1,
    CMD_CTRL_WR = 2'd2,
    CMD_CAL_WR  = 2'd3
  } sdh_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_DONE
  } sdh_state_e;
endpackage

// File: rtl/sdh_byte_rev.sv
module sdh_byte_rev #(
  parameter int W = 24
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NBYTES = W / 8;
  logic [W-1:0] flipped;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign flipped[8*b+i] = din[8*b+7-i];
    end
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/sdh_tick_gen.sv
module sdh_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sdh_shifter.sv
module sdh_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         fall,
  input  logic         rise,
  input  logic         sd_in,
  output logic         out_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx      <= '0;
      out_bit <= 1'b0;
      rx_word <= '0;
    end else if (load) begin
      tx      <= load_word;
      rx_word <= '0;
    end else begin
      if (fall) begin
        out_bit <= tx[W-1];
        tx      <= {tx[W-2:0], 1'b0};
      end
      if (rise) rx_word <= {rx_word[W-2:0], sd_in};
    end
  end
endmodule

// File: rtl/sdh_pin_map.sv
module sdh_pin_map (
  input  logic clk,
  input  logic rst,
  input  logic cfg_tfs_inv,
  input  logic cfg_a0_tfs,
  input  logic rd_frame,
  input  logic wr_frame,
  input  logic a0_sel,
  input  logic sclk_int,
  input  logic bit_int,
  output logic sclk,
  output logic rfs_n,
  output logic tfs_n,
  output logic a0,
  output logic sd_out,
  output logic sd_oe
);
  logic rfs_d, tfs_d, a0_d;

  always_comb begin
    rfs_d = ~rd_frame;
    // Transmit strobe may be derived from the receive strobe, never the reverse.
    tfs_d = cfg_tfs_inv ? rd_frame : ~wr_frame;
    a0_d  = cfg_a0_tfs ? tfs_d : a0_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk   <= 1'b1;
      rfs_n  <= 1'b1;
      tfs_n  <= 1'b1;
      a0     <= 1'b0;
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else begin
      sclk   <= sclk_int;
      rfs_n  <= rfs_d;
      tfs_n  <= tfs_d;
      a0     <= a0_d;
      sd_out <= bit_int;
      sd_oe  <= ~tfs_d;
    end
  end
endmodule

// File: rtl/sdadc_host_ctrl.sv
module sdadc_host_ctrl #(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_byte_rev,
  input  logic              cfg_tfs_inv,
  input  logic              cfg_a0_tfs,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic              adc_drdy_n,
  output logic              adc_sclk,
  output logic              adc_rfs_n,
  output logic              adc_tfs_n,
  output logic              adc_a0,
  output logic              adc_sd_out,
  output logic              adc_sd_oe,
  input  logic              adc_sd_in
);
  import sdh_pkg::*;

  localparam int BCW = $clog2(WORD_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

  sdh_state_e        state;
  sdh_cmd_e          cmd_q, cmd_in;
  logic              a0_sel_q, sclk_q, ack_q;
  logic [BCW-1:0]    bit_cnt;
  logic [WORD_W-1:0] rdata_q, tx_word, rx_word, rx_user;
  logic              in_frame, is_read, rd_frame, wr_frame;
  logic              tick, accept, fall_ev, rise_ev, out_bit;

  assign cmd_in   = sdh_cmd_e'(req_cmd);
  assign accept   = (state == ST_IDLE) && req_valid && !ack_q;
  assign in_frame = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TAIL);
  assign is_read  = (cmd_q == CMD_DATA_RD) || (cmd_q == CMD_CTRL_RD);
  assign rd_frame = in_frame && is_read;
  assign wr_frame = in_frame && !is_read;
  assign fall_ev  = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && sclk_q));
  assign rise_ev  = tick && (state == ST_SHIFT) && !sclk_q;

  sdh_byte_rev #(.W(WORD_W)) tx_rev_i (.en(cfg_byte_rev), .din(req_wdata), .dout(tx_word));
  sdh_byte_rev #(.W(WORD_W)) rx_rev_i (.en(cfg_byte_rev), .din(rx_word),   .dout(rx_user));

  sdh_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk(clk), .rst(rst), .en(in_frame), .tick(tick)
  );

  sdh_shifter #(.W(WORD_W)) shift_i (
    .clk(clk), .rst(rst), .load(accept), .load_word(tx_word),
    .fall(fall_ev), .rise(rise_ev), .sd_in(adc_sd_in),
    .out_bit(out_bit), .rx_word(rx_word)
  );

  sdh_pin_map pins_i (
    .clk(clk), .rst(rst), .cfg_tfs_inv(cfg_tfs_inv), .cfg_a0_tfs(cfg_a0_tfs),
    .rd_frame(rd_frame), .wr_frame(wr_frame), .a0_sel(a0_sel_q),
    .sclk_int(sclk_q), .bit_int(out_bit),
    .sclk(adc_sclk), .rfs_n(adc_rfs_n), .tfs_n(adc_tfs_n), .a0(adc_a0),
    .sd_out(adc_sd_out), .sd_oe(adc_sd_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_q    <= CMD_DATA_RD;
      a0_sel_q <= 1'b0;
      sclk_q   <= 1'b1;
      bit_cnt  <= '0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          cmd_q    <= cmd_in;
          a0_sel_q <= (cmd_in == CMD_DATA_RD) || (cmd_in == CMD_CAL_WR);
          bit_cnt  <= '0;
          if ((cmd_in == CMD_CTRL_RD) && cfg_a0_tfs) state <= ST_DONE;
          else if (cmd_in == CMD_DATA_RD)            state <= ST_WAIT;
          else                                       state <= ST_LEAD;
        end
        ST_WAIT: if (!adc_drdy_n) state <= ST_LEAD;
        ST_LEAD: if (tick) begin
          sclk_q <= 1'b0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (bit_cnt == LAST_BIT) state <= ST_TAIL;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end else begin
            sclk_q <= 1'b0;
          end
        end
        ST_TAIL: if (tick) state <= ST_DONE;
        ST_DONE: begin
          ack_q   <= 1'b1;
          rdata_q <= rx_user;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ack   = ack_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sdadc_host_ctrl_chk.sv
module sdadc_host_ctrl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic cfg_tfs_inv,
  input logic cfg_a0_tfs,
  input logic req_ack,
  input logic adc_drdy_n,
  input logic adc_sclk,
  input logic adc_rfs_n,
  input logic adc_tfs_n,
  input logic adc_a0,
  input logic adc_sd_out,
  input logic adc_sd_oe
);
  logic        prev_q;
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      prev_q <= adc_sclk;
      if (adc_sclk != prev_q)  run_q <= 16'd1;
      else if (run_q != '1)    run_q <= run_q + 16'd1;
    end
  end

  p_drdy_gate_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_rfs_n) && adc_a0) |-> !$past(adc_drdy_n, 2));

  p_sd_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!adc_tfs_n && adc_sclk && prev_q) |-> $stable(adc_sd_out));

  p_oe_read_r7: assert property (@(posedge clk) disable iff (rst)
    !adc_rfs_n |-> !adc_sd_oe);

  p_sclk_low_r8: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk && !prev_q) |-> (run_q == 16'(HALF_DIV)));

  p_tfs_inv_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_tfs_inv && $past(cfg_tfs_inv)) |-> (adc_tfs_n != adc_rfs_n));

  p_a0_tfs_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_a0_tfs && $past(cfg_a0_tfs)) |-> (adc_a0 == adc_tfs_n));

  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  p_frames_excl_r12: assert property (@(posedge clk) disable iff (rst)
    (!cfg_tfs_inv && !$past(cfg_tfs_inv)) |-> (adc_rfs_n || adc_tfs_n));

  p_sclk_frame_r13: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> (!adc_rfs_n || !adc_tfs_n));
endmodule

bind sdadc_host_ctrl sdadc_host_ctrl_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk(clk), .rst(rst), .cfg_tfs_inv(cfg_tfs_inv), .cfg_a0_tfs(cfg_a0_tfs),
  .req_ack(req_ack), .adc_drdy_n(adc_drdy_n), .adc_sclk(adc_sclk),
  .adc_rfs_n(adc_rfs_n), .adc_tfs_n(adc_tfs_n), .adc_a0(adc_a0),
  .adc_sd_out(adc_sd_out), .adc_sd_oe(adc_sd_oe)
);

// File: tb/sdadc_host_ctrl_tb_top.sv
module sdadc_host_ctrl_tb_top;
  localparam int W = 24;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_byte_rev = 0, cfg_tfs_inv = 0, cfg_a0_tfs = 0;
  logic req_valid = 0;
  logic [1:0] req_cmd = 0;
  logic [W-1:0] req_wdata = 0;
  logic req_ack;
  logic [W-1:0] rsp_rdata;
  logic adc_drdy_n = 1'b1;
  logic adc_sclk, adc_rfs_n, adc_tfs_n, adc_a0, adc_sd_out, adc_sd_oe;
  logic adc_sd_in = 1'b0;

  always #2.5 clk = ~clk;

  sdadc_host_ctrl #(.WORD_W(W), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .cfg_byte_rev(cfg_byte_rev), .cfg_tfs_inv(cfg_tfs_inv),
    .cfg_a0_tfs(cfg_a0_tfs), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .adc_drdy_n(adc_drdy_n), .adc_sclk(adc_sclk), .adc_rfs_n(adc_rfs_n),
    .adc_tfs_n(adc_tfs_n), .adc_a0(adc_a0), .adc_sd_out(adc_sd_out),
    .adc_sd_oe(adc_sd_oe), .adc_sd_in(adc_sd_in)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int cyc = 0;

  // converter model and line monitors
  logic [W-1:0] conv_word = '0;
  logic [W-1:0] wr_cap = '0;
  int conv_idx = 0;
  int rd_bits, rd_a0_hi, rd_oe_hi, wr_bits, wr_a0_hi, wr_oe_lo, rfs_falls, sclk_bad;
  int fall_cyc = 0, rise_cyc = 0, rises = 0;

  always @(posedge clk) cyc++;

  always @(negedge adc_rfs_n) begin
    conv_idx = 0;
    rfs_falls++;
  end

  always @(negedge adc_sclk) begin
    if (!adc_rfs_n) begin
      adc_sd_in = (conv_idx < W) ? conv_word[W-1-conv_idx] : 1'b0;
      conv_idx++;
    end
    if (rises > 0 && (cyc - rise_cyc) != HALF) sclk_bad++;
    fall_cyc = cyc;
  end

  always @(posedge adc_sclk) begin
    if ((cyc - fall_cyc) != HALF) sclk_bad++;
    rise_cyc = cyc;
    rises++;
    if (!adc_rfs_n) begin
      rd_bits++;
      if (adc_a0) rd_a0_hi++;
      if (adc_sd_oe) rd_oe_hi++;
    end
    if (!adc_tfs_n) begin
      wr_cap = {wr_cap[W-2:0], adc_sd_out};
      wr_bits++;
      if (adc_a0) wr_a0_hi++;
      if (!adc_sd_oe) wr_oe_lo++;
    end
  end

  task automatic clr_mon();
    rd_bits = 0; rd_a0_hi = 0; rd_oe_hi = 0;
    wr_bits = 0; wr_a0_hi = 0; wr_oe_lo = 0;
    rfs_falls = 0; sclk_bad = 0; rises = 0; wr_cap = '0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] cmd, input logic [W-1:0] wd);
    @(negedge clk);
    req_cmd = cmd; req_wdata = wd; req_valid = 1'b1;
  endtask

  task automatic wait_ack(output logic [W-1:0] rd, output bit pins_idle);
    bit got = 0;
    rd = '0; pins_idle = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (req_ack) begin
        got = 1;
        rd = rsp_rdata;
        pins_idle = adc_rfs_n && adc_tfs_n && adc_sclk;
        req_valid = 1'b0;
      end
    end
    check(got, "R12 ack seen", {31'd0, got}, 32'd1);
    @(negedge clk);
    check(!req_ack, "R12 ack one cycle", {31'd0, req_ack}, 32'd0);
  endtask

  task automatic t_reset();
    check(adc_rfs_n && adc_tfs_n && adc_sclk, "R1 idle strobes and clock",
          {29'd0, adc_rfs_n, adc_tfs_n, adc_sclk}, 32'd7);
    check(!req_ack && !adc_sd_oe, "R1 ack and oe low", {30'd0, req_ack, adc_sd_oe}, 32'd0);
  endtask

  task automatic t_data_read();
    logic [W-1:0] rd; bit idle;
    clr_mon();
    conv_word = 24'hA5C33C;
    adc_drdy_n = 1'b1;
    issue(2'd0, '0);
    repeat (80) @(negedge clk);
    check(rfs_falls == 0, "R2 no frame while not ready", rfs_falls, 0);
    adc_drdy_n = 1'b0;
    wait_ack(rd, idle);
    adc_drdy_n = 1'b1;
    check(rd == 24'hA5C33C, "R3 conversion word", rd, 24'hA5C33C);
    check(rd_bits == 24 && rd_a0_hi == 24, "R3 a0 high for 24 bits", rd_a0_hi, 24);
    check(rd_oe_hi == 0, "R7 line released on read", rd_oe_hi, 0);
    check(sclk_bad == 0, "R8 half period", sclk_bad, 0);
    check(idle, "R13 pins idle at ack", {31'd0, idle}, 1);
  endtask

  task automatic t_ctrl_read();
    logic [W-1:0] rd; bit idle;
    clr_mon();
    conv_word = 24'h13579B;
    adc_drdy_n = 1'b1;
    issue(2'd1, '0);
    wait_ack(rd, idle);
    check(rd == 24'h13579B, "R4 control word without ready", rd, 24'h13579B);
    check(rd_bits == 24 && rd_a0_hi == 0, "R4 a0 low", rd_a0_hi, 0);
  endtask

  task automatic t_ctrl_write();
    logic [W-1:0] rd; bit idle;
    clr_mon();
    issue(2'd2, 24'hC0FFEE);
    wait_ack(rd, idle);
    check(wr_cap == 24'hC0FFEE && wr_bits == 24, "R5 control write word", wr_cap, 24'hC0FFEE);
    check(wr_a0_hi == 0, "R5 a0 low", wr_a0_hi, 0);
    check(wr_oe_lo == 0, "R7 oe on during write", wr_oe_lo, 0);
    check(rfs_falls == 0, "R12 no receive frame on write", rfs_falls, 0);
    check(sclk_bad == 0, "R8 half period on write", sclk_bad, 0);
    check(idle, "R13 pins idle after write", {31'd0, idle}, 1);
  endtask

  task automatic t_cal_write();
    logic [W-1:0] rd; bit idle;
    clr_mon();
    issue(2'd3, 24'h5A0F81);
    wait_ack(rd, idle);
    check(wr_cap == 24'h5A0F81, "R6 calibration word", wr_cap, 24'h5A0F81);
    check(wr_a0_hi == 24, "R6 a0 high", wr_a0_hi, 24);
  endtask

  task automatic t_byte_rev();
    logic [W-1:0] rd; bit idle;
    cfg_byte_rev = 1'b1;
    clr_mon();
    issue(2'd2, 24'h010203);
    wait_ack(rd, idle);
    check(wr_cap == 24'h8040C0, "R11 write reversed per byte", wr_cap, 24'h8040C0);
    clr_mon();
    conv_word = 24'h80C001;
    adc_drdy_n = 1'b0;
    issue(2'd0, '0);
    wait_ack(rd, idle);
    adc_drdy_n = 1'b1;
    check(rd == 24'h010380, "R11 read reversed per byte", rd, 24'h010380);
    cfg_byte_rev = 1'b0;
  endtask

  task automatic t_tfs_inv();
    logic [W-1:0] rd; bit idle;
    cfg_tfs_inv = 1'b1;
    repeat (3) @(negedge clk);
    check(adc_rfs_n && !adc_tfs_n, "R9 idle transmit strobe inverted",
          {30'd0, adc_rfs_n, adc_tfs_n}, 32'd2);
    clr_mon();
    issue(2'd2, 24'h7E1234);
    wait_ack(rd, idle);
    check(wr_cap == 24'h7E1234 && rfs_falls == 0, "R9 write with rfs high", wr_cap, 24'h7E1234);
    clr_mon();
    conv_word = 24'h0BEEF0;
    adc_drdy_n = 1'b0;
    issue(2'd0, '0);
    wait_ack(rd, idle);
    adc_drdy_n = 1'b1;
    check(rd == 24'h0BEEF0 && wr_bits == 0, "R9 read in inverted mode", rd, 24'h0BEEF0);
    cfg_tfs_inv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_a0_tfs();
    logic [W-1:0] rd; bit idle;
    cfg_a0_tfs = 1'b1;
    repeat (3) @(negedge clk);
    clr_mon();
    issue(2'd3, 24'h24680A);
    wait_ack(rd, idle);
    check(wr_cap == 24'h24680A && wr_a0_hi == 0, "R10 calibration write lands a0 low",
          wr_a0_hi, 0);
    clr_mon();
    conv_word = 24'hFFFFFF;
    issue(2'd1, '0);
    wait_ack(rd, idle);
    check(rd == 24'h0 && rfs_falls == 0, "R10 control read refused", rd, 0);
    clr_mon();
    conv_word = 24'h3C3C3C;
    adc_drdy_n = 1'b0;
    issue(2'd0, '0);
    wait_ack(rd, idle);
    adc_drdy_n = 1'b1;
    check(rd == 24'h3C3C3C && rd_a0_hi == 24, "R10 data read a0 high", rd_a0_hi, 24);
    cfg_a0_tfs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr_mon();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data_read();
    t_ctrl_read();
    t_ctrl_write();
    t_cal_write();
    t_byte_rev();
    t_tfs_inv();
    t_a0_tfs();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule